// File: doc/BRIEF.md
# SPI Controller with Selectable Slave-Select Role

This block is a byte-wide SPI controller that works either as bus master or as a selected slave. Software talks to it through a two-address register port. Address 0 holds the mode and configuration bits. Address 1 holds the data byte that is sent next and, after each byte, the byte just received. In master mode a start strobe launches one byte on SCK/MOSI/MISO. SCK idles low, bits are sampled on the rising edge, and SCK runs at a fixed fraction of the system clock. A one-cycle done pulse marks the end of every byte.

Two configuration bits decide what the slave-select pin means to a master. It can be ignored, watched as a mode-fault input, or driven as an automatic select output. A mode fault makes the master give up the bus at once. In master mode, changing the bit order or any select-related setting in the middle of a byte cancels that byte.

In slave mode the SCK, MOSI and SS pins are sampled as inputs that are already synchronous to the system clock. MISO is driven only while the block is selected.

Top module: `spi_ss_ctl`

## Requirements
- R1: After reset the control register and the data register read 0. busy, done, mode_fault, sck_o and all output enables are 0, and ss_o is 1.
- R2: The control register is at address 0 and has these bits: bit0 master enable, bit1 LSB-first, bit2 mode-fault enable, bit3 SS output enable. Bits 7:4 ignore writes and read 0. The data register is at address 1. reg_rdata shows the register selected by reg_addr in the same cycle.
- R3: A start in master mode while idle and fault-free raises busy at the next clock edge. busy stays high for (2*W+1)*DIV/2 cycles (34 cycles by default). During that time the first half-period holds SCK low, then W SCK pulses follow (high half, then low half), and the rising edges sample miso_i. In the cycle after busy falls, done is 1 for one cycle and the data register holds the received byte.
- R4: With LSB-first at 0, bit 7 of the byte goes first on mosi_o/miso_o and arrives first on the input. With LSB-first at 1, bit 0 goes first and arrives first. In both orders the data register keeps the byte's MSB in bit 7, and MOSI changes only while SCK is low.
- R5: When master enable, mode-fault enable and SS output enable are all 1, ss_oe is 1. ss_o is then low for the whole busy period and high otherwise, so it falls one half-period before the first SCK rise and rises one half-period after the last SCK fall.
- R6: In master mode with mode-fault enable at 0, ss_oe is 0 and a low ss_i neither raises mode_fault nor disturbs a transfer.
- R7: In master mode with mode-fault enable at 1 and SS output enable at 0, ss_i low at a clock edge has these effects at that edge: mode_fault is set, busy clears with no done, the master enable bit clears, and sck_oe and mosi_oe drop. mode_fault stays set until the next control write.
- R8: During a master transfer, a control write that changes master enable, LSB-first, mode-fault enable or SS output enable ends busy at that edge. No done follows, SCK returns low and ss_o goes high.
- R9: In slave mode ss_oe is 0 for every setting of the select bits. While ss_i is low, miso_oe is 1. Each rising sck_i shifts in mosi_i, and each falling sck_i moves miso_o to the next bit. The W-th rising edge gives a one-cycle done and loads the byte into the data register.
- R10: start is ignored while master enable is 0 and while a master transfer is already running. A running transfer keeps its length.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 1 | 0 = control, 1 = data |
| reg_wdata | input | W | Write data |
| reg_rdata | output | W | Read data of the addressed register |
| start | input | 1 | Launch a master byte |
| busy | output | 1 | Master byte in progress |
| done | output | 1 | One-cycle end-of-byte pulse |
| mode_fault | output | 1 | Sticky mode-fault flag |
| sck_o | output | 1 | SCK driven as master |
| sck_oe | output | 1 | SCK output enable |
| sck_i | input | 1 | SCK sampled as slave |
| mosi_o | output | 1 | MOSI driven as master |
| mosi_oe | output | 1 | MOSI output enable |
| mosi_i | input | 1 | MOSI sampled as slave |
| miso_i | input | 1 | MISO sampled as master |
| miso_o | output | 1 | MISO driven as slave |
| miso_oe | output | 1 | MISO output enable |
| ss_i | input | 1 | Slave-select pin input |
| ss_o | output | 1 | Slave-select pin output |
| ss_oe | output | 1 | Slave-select output enable |

## Verification
The bench uses the default W = 8 and DIV = 4. A whole byte therefore takes only 34 cycles, and a cycle-by-cycle model can compare SCK, MOSI, SS, busy and done at every single half-period edge. Patterns that are not symmetric tell MSB-first from LSB-first on both data directions. The short byte also makes it cheap to place a mode fault, a configuration change or an extra start at an exact cycle inside the transfer.

// File: rtl/spi_ss_ctl.sv
module spi_ss_ctl #(
  parameter int W   = 8,
  parameter int DIV = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         reg_we,
  input  logic         reg_addr,
  input  logic [W-1:0] reg_wdata,
  output logic [W-1:0] reg_rdata,
  input  logic         start,
  output logic         busy,
  output logic         done,
  output logic         mode_fault,
  output logic         sck_o,
  output logic         sck_oe,
  input  logic         sck_i,
  output logic         mosi_o,
  output logic         mosi_oe,
  input  logic         mosi_i,
  input  logic         miso_i,
  output logic         miso_o,
  output logic         miso_oe,
  input  logic         ss_i,
  output logic         ss_o,
  output logic         ss_oe
);
  localparam int HALF = DIV / 2;
  localparam int HN   = 2 * W + 1;
  localparam int HCW  = $clog2(HN + 1);
  localparam int CCW  = (HALF > 1) ? $clog2(HALF) : 1;
  localparam int BCW  = $clog2(W + 1);

  logic mstr, lsbf, flt_en, sso_en;
  logic [W-1:0] dreg, tx, rx;
  logic [HCW-1:0] hcnt;
  logic [CCW-1:0] ccnt;
  logic [BCW-1:0] bcnt;
  logic sck_q;

  wire cwr      = reg_we && !reg_addr;
  wire dwr      = reg_we && reg_addr;
  wire ss_mon   = mstr && flt_en && !sso_en;
  wire fault    = ss_mon && !ss_i;
  wire cfg_chg  = cwr && (reg_wdata[3:0] != {sso_en, flt_en, lsbf, mstr});
  wire half_end = (ccnt == CCW'(HALF - 1));
  wire m_last   = half_end && (hcnt == HCW'(HN - 1));
  wire in_bit   = mstr ? miso_i : mosi_i;
  wire out_bit  = lsbf ? tx[0] : tx[W-1];
  wire s_rise   = !ss_i && sck_i && !sck_q;
  wire s_fall   = !ss_i && !sck_i && sck_q;
  wire [W-1:0] rx_nxt = lsbf ? {in_bit, rx[W-1:1]} : {rx[W-2:0], in_bit};
  wire [W-1:0] tx_nxt = lsbf ? {1'b0, tx[W-1:1]} : {tx[W-2:0], 1'b0};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      {sso_en, flt_en, lsbf, mstr} <= '0;
      mode_fault <= 1'b0;
    end else if (fault) begin
      mode_fault <= 1'b1;
      mstr       <= 1'b0;
    end else if (cwr) begin
      {sso_en, flt_en, lsbf, mstr} <= reg_wdata[3:0];
      mode_fault <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dreg  <= '0;
      tx    <= '0;
      rx    <= '0;
      hcnt  <= '0;
      ccnt  <= '0;
      bcnt  <= '0;
      busy  <= 1'b0;
      done  <= 1'b0;
      sck_q <= 1'b0;
    end else begin
      done  <= 1'b0;
      sck_q <= sck_i;
      if (dwr) dreg <= reg_wdata;
      if (fault || (busy && cfg_chg)) begin
        busy <= 1'b0;
      end else if (busy) begin
        if (m_last) begin
          busy <= 1'b0;
          done <= 1'b1;
          dreg <= rx;
        end else if (half_end) begin
          ccnt <= '0;
          hcnt <= hcnt + 1'b1;
          if (hcnt[0]) tx <= tx_nxt;
          else         rx <= rx_nxt;
        end else begin
          ccnt <= ccnt + 1'b1;
        end
      end else if (mstr) begin
        if (start) begin
          busy <= 1'b1;
          hcnt <= '0;
          ccnt <= '0;
          tx   <= dreg;
        end
      end else if (ss_i) begin
        tx   <= dreg;
        bcnt <= '0;
      end else begin
        if (s_rise) begin
          rx <= rx_nxt;
          if (bcnt == BCW'(W - 1)) begin
            bcnt <= '0;
            done <= 1'b1;
            dreg <= rx_nxt;
          end else begin
            bcnt <= bcnt + 1'b1;
          end
        end
        if (s_fall) tx <= tx_nxt;
      end
    end
  end

  assign reg_rdata = reg_addr ? dreg : {{(W-4){1'b0}}, sso_en, flt_en, lsbf, mstr};
  assign sck_o     = busy && hcnt[0];
  assign sck_oe    = mstr;
  assign mosi_o    = busy && out_bit;
  assign mosi_oe   = mstr;
  assign miso_o    = out_bit;
  assign miso_oe   = !mstr && !ss_i;
  assign ss_oe     = mstr && flt_en && sso_en;
  assign ss_o      = !(busy && ss_oe);

  p_done_single_r3: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  p_fault_release_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (ss_mon && !ss_i) |=> (mode_fault && !busy && !sck_oe && !mosi_oe));

  p_cfg_abort_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && cfg_chg) |=> (!busy && !done));

  p_start_only_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(start && mstr));

  p_slave_no_ss_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !mstr) |-> !ss_oe);
endmodule

// File: tb/spi_ss_ctl_test.sv
`timescale 1ns/1ps
module spi_ss_ctl_test;
  localparam int W = 8;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic rst_n, reg_we, reg_addr, start, sck_i, mosi_i, miso_i, ss_i;
  logic [W-1:0] reg_wdata, reg_rdata;
  logic busy, done, mode_fault, sck_o, sck_oe, mosi_o, mosi_oe, miso_o, miso_oe, ss_o, ss_oe;

  spi_ss_ctl #(.W(W), .DIV(4)) uut (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .start(start), .busy(busy),
    .done(done), .mode_fault(mode_fault), .sck_o(sck_o), .sck_oe(sck_oe),
    .sck_i(sck_i), .mosi_o(mosi_o), .mosi_oe(mosi_oe), .mosi_i(mosi_i),
    .miso_i(miso_i), .miso_o(miso_o), .miso_oe(miso_oe), .ss_i(ss_i),
    .ss_o(ss_o), .ss_oe(ss_oe));

  int tests = 0;
  int fails = 0;

  task automatic chk(input string r, input logic [31:0] a, input logic [31:0] e);
    tests++;
    if (a !== e) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", r, a, e);
    end
  endtask

  task automatic wr(input logic a, input logic [7:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd(input logic a, output logic [7:0] d);
    reg_addr = a;
    #1;
    d = reg_rdata;
  endtask

  function automatic logic wbit(input logic [7:0] b, input int idx, input logic lsb);
    if (idx > 7) return 1'b0;
    return lsb ? b[idx] : b[7-idx];
  endfunction

  task automatic count_done(input int n, output int c);
    c = 0;
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      if (done) c++;
    end
  endtask

  task automatic master_xfer(input logic [7:0] txb, input logic [7:0] rxb,
                             input logic lsb, input logic sso, input string r);
    logic [7:0] d;
    wr(1'b1, txb);
    start = 1'b1;
    miso_i = wbit(rxb, 0, lsb);
    @(negedge clk);
    start = 1'b0;
    for (int t = 0; t < 34; t++) begin
      int h;
      h = t / 2;
      chk({r, " cycle"}, {busy, sck_o, mosi_o, ss_o, done},
          {1'b1, (h % 2 == 1), wbit(txb, h / 2, lsb), !sso, 1'b0});
      miso_i = wbit(rxb, h / 2, lsb);
      @(negedge clk);
    end
    chk({r, " end R3"}, {busy, sck_o, ss_o, done}, 4'b0011);
    rd(1'b1, d);
    chk({r, " rx R4"}, d, rxb);
    @(negedge clk);
    chk({r, " done width R3"}, done, 1'b0);
  endtask

  task automatic slave_xfer(input logic [7:0] txb, input logic [7:0] mb, input logic lsb);
    logic [7:0] d;
    wr(1'b1, txb);
    wr(1'b0, {6'd0, lsb, 1'b0});
    ss_i = 1'b0;
    @(negedge clk);
    chk("R9 miso_oe when selected", {miso_oe, ss_oe, busy}, 3'b100);
    for (int i = 0; i < 8; i++) begin
      sck_i = 1'b0;
      mosi_i = wbit(mb, i, lsb);
      @(negedge clk);
      chk("R9 R4 slave miso bit", miso_o, wbit(txb, i, lsb));
      sck_i = 1'b1;
      @(negedge clk);
      chk("R9 slave done timing", done, (i == 7));
    end
    @(negedge clk);
    chk("R9 slave done one cycle", done, 1'b0);
    rd(1'b1, d);
    chk("R9 R4 slave rx byte", d, mb);
    sck_i = 1'b0;
    ss_i = 1'b1;
    @(negedge clk);
    chk("R9 miso_oe released", miso_oe, 1'b0);
  endtask

  initial begin
    logic [7:0] d;
    int c;
    rst_n = 1'b0; reg_we = 1'b0; reg_addr = 1'b0; reg_wdata = '0; start = 1'b0;
    sck_i = 1'b0; mosi_i = 1'b0; miso_i = 1'b0; ss_i = 1'b1;
    repeat (3) @(negedge clk);
    chk("R1 reset outputs", {busy, done, mode_fault, sck_o, sck_oe, mosi_oe, miso_oe, ss_oe, ss_o},
        9'b000000001);
    rd(1'b0, d); chk("R1 reset ctrl", d, 8'h00);
    rd(1'b1, d); chk("R1 reset data", d, 8'h00);
    rst_n = 1'b1;

    wr(1'b0, 8'hF0); rd(1'b0, d); chk("R2 reserved bits ignored", d, 8'h00);
    wr(1'b0, 8'hFA); rd(1'b0, d); chk("R2 ctrl readback", d, 8'h0A);
    chk("R9 slave ss_oe with sso set", ss_oe, 1'b0);
    wr(1'b0, 8'h0C); chk("R9 slave ss_oe fault+sso", ss_oe, 1'b0);

    wr(1'b0, 8'h01);
    chk("R6 ss unused ss_oe", ss_oe, 1'b0);
    master_xfer(8'hB4, 8'h2D, 1'b0, 1'b0, "R3 R4 msb-first");
    wr(1'b0, 8'h03);
    master_xfer(8'h1E, 8'hC1, 1'b1, 1'b0, "R4 lsb-first");

    wr(1'b0, 8'h0D);
    chk("R5 ss_oe driven", {ss_oe, ss_o}, 2'b11);
    master_xfer(8'h5A, 8'h81, 1'b0, 1'b1, "R5 ss output");

    wr(1'b0, 8'h01);
    ss_i = 1'b0;
    master_xfer(8'hE7, 8'h3C, 1'b0, 1'b0, "R6 ss low ignored");
    chk("R6 no fault", mode_fault, 1'b0);
    ss_i = 1'b1;

    wr(1'b1, 8'hFF);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    c = 0;
    for (int t = 0; t < 60; t++) begin
      if (busy) c++;
      start = (t == 5);
      @(negedge clk);
    end
    start = 1'b0;
    chk("R10 start during busy ignored", c, 34);

    wr(1'b0, 8'h00);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk("R10 start in slave ignored", busy, 1'b0);

    wr(1'b0, 8'h01);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    repeat (9) @(negedge clk);
    wr(1'b0, 8'h03);
    chk("R8 lsb change aborts", {busy, sck_o, ss_o}, 3'b001);
    count_done(40, c);
    chk("R8 no done after abort", c, 0);

    wr(1'b0, 8'h05);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    repeat (6) @(negedge clk);
    wr(1'b0, 8'h0D);
    chk("R8 ss output enable change aborts", busy, 1'b0);
    count_done(40, c);
    chk("R8 no done after sso abort", c, 0);

    wr(1'b0, 8'h05);
    chk("R7 monitored ss_oe", ss_oe, 1'b0);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    repeat (6) @(negedge clk);
    ss_i = 1'b0;
    @(negedge clk);
    chk("R7 fault response", {mode_fault, busy, sck_oe, mosi_oe}, 4'b1000);
    rd(1'b0, d); chk("R7 master bit cleared", d, 8'h04);
    count_done(40, c);
    chk("R7 no done after fault", c, 0);
    ss_i = 1'b1;
    @(negedge clk);
    chk("R7 fault sticky", mode_fault, 1'b1);
    wr(1'b0, 8'h05);
    chk("R7 fault cleared by ctrl write", mode_fault, 1'b0);
    rd(1'b0, d); chk("R7 ctrl after clear", d, 8'h05);

    wr(1'b0, 8'h00);
    slave_xfer(8'h6C, 8'hA3, 1'b0);
    slave_xfer(8'h71, 8'h4E, 1'b1);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    tests++;
    fails++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule